// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer with Replay Buffer

This block owns the fetch program counter of a small core and runs a single-level hardware loop beside it. One setup command supplies the first address of the loop body, the last address of the body and an iteration count. While the loop is armed, the sequencer compares every fetch address with the last address of the body. If iterations remain, the next fetch goes back to the first address of the body. No branch instruction is needed and no idle cycle is inserted.

A small replay buffer sits beside the fetch port. On the first pass through the body, each word read from instruction memory is copied into the buffer, indexed by its distance from the first address of the body. On later passes, the sequencer serves those words from the buffer in the same cycle and does not request memory. No setup is needed for the buffer. If the body is longer than the buffer, every pass is fetched from memory as normal. A flush input stops the loop and empties the buffer.

Top module: `hwloop_sequencer`

## Requirements
- R1: While reset is asserted, the fetch address is RESET_PC (default 0), loop_active is 0, instr_from_buf is 0 and imem_req is 1.
- R2: A setup command is taken in a single cycle with setup_valid high. loop_active reads 1 from the next fetch onward.
- R3: If the fetch address equals the last address of the body and more than one iteration remains, the next fetch address is the first address of the body. This happens in the very next cycle, with no idle cycle.
- R4: A count of N runs the body N times in all. After the last pass, fetch goes on to the last address plus one and loop_active falls to 0.
- R5: A count of 0 is treated as a count of 1, so the body runs exactly once.
- R6: If the first and last addresses are equal, that single instruction is fetched count times in a row.
- R7: If the body holds at most DEPTH words, the first pass is read from memory. Every word of later passes is delivered from the buffer in the cycle of its fetch, with imem_req at 0, instr_from_buf at 1 and the same data that memory holds.
- R8: If the body holds more than DEPTH words, the loop still repeats, but every fetch comes from memory, with imem_req at 1 and instr_from_buf at 0.
- R9: flush stops the loop. The next fetch is the current address plus one, even when the current address is the last address of the body, and loop_active reads 0 from then on. From the cycle after the flush, no fetch is served from the buffer.
- R10: Outside a redirect, the fetch address goes up by exactly one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup command strobe |
| setup_start | input | AW | First address of the loop body |
| setup_end | input | AW | Last address of the loop body, not below setup_start |
| setup_count | input | CW | Iteration count; 0 acts as 1 |
| flush | input | 1 | Stop the loop and empty the buffer |
| imem_req | output | 1 | Instruction memory read request for this cycle |
| imem_addr | output | AW | Instruction memory read address |
| imem_rdata | input | IW | Instruction memory read data, valid in the same cycle |
| instr_pc | output | AW | Address of the instruction delivered this cycle |
| instr_data | output | IW | Instruction delivered this cycle |
| instr_from_buf | output | 1 | Instruction came from the replay buffer |
| loop_active | output | 1 | A loop is armed |

## Verification
The hardest thing to show from the ports is that later passes really come from the buffer. The buffer holds exactly the words memory would return, so correct data alone proves nothing. The bench's memory model therefore returns a poison word whenever imem_req is low. Correct data on those cycles can then only come from the buffer. The second hard case is a flush that lands on the last address of the body while iterations remain, where the redirect and the flush meet in one cycle. The bench reaches it by counting fetch cycles from the setup command and raising flush in exactly that cycle.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

   // Source of the instruction delivered in a fetch cycle
   typedef enum logic {
      SRC_MEM = 1'b0,
      SRC_BUF = 1'b1
   } fetch_src_e;

   localparam int unsigned DEF_ADDR_W  = 16;
   localparam int unsigned DEF_INSTR_W = 32;
   localparam int unsigned DEF_COUNT_W = 16;
   localparam int unsigned DEF_DEPTH   = 8;

endpackage

// File: rtl/hwloop_ctrl.sv
// Loop bounds, remaining-iteration counter and redirect decision.
module hwloop_ctrl #(
   parameter int unsigned AW    = 16,
   parameter int unsigned CW    = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          setup_valid,
   input  logic [AW-1:0] setup_start,
   input  logic [AW-1:0] setup_end,
   input  logic [CW-1:0] setup_count,
   input  logic          flush,
   input  logic [AW-1:0] fetch_pc,
   output logic          active_o,
   output logic          redirect_o,
   output logic [AW-1:0] start_o,
   output logic          fits_o,
   output logic          in_body_o
);

   localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);
   localparam logic [CW-1:0] ONE_C   = CW'(1);

   logic          active_q;
   logic [CW-1:0] remain_q;
   logic [AW-1:0] start_q;
   logic [AW-1:0] end_q;
   logic          fits_q;
   logic          at_end;
   logic          setup_fits;
   logic [AW-1:0] setup_span;

   assign setup_span = setup_end - setup_start;
   assign setup_fits = (setup_end >= setup_start) && (setup_span < DEPTH_A);
   assign at_end     = active_q && (fetch_pc == end_q);
   assign redirect_o = at_end && (remain_q > ONE_C) && !flush && !setup_valid;
   assign in_body_o  = active_q && (fetch_pc >= start_q) && (fetch_pc <= end_q);
   assign active_o   = active_q;
   assign start_o    = start_q;
   assign fits_o     = fits_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         remain_q <= '0;
         start_q  <= '0;
         end_q    <= '0;
         fits_q   <= 1'b0;
      end else if (flush) begin
         active_q <= 1'b0;
      end else if (setup_valid) begin
         active_q <= 1'b1;
         remain_q <= (setup_count == '0) ? ONE_C : setup_count;
         start_q  <= setup_start;
         end_q    <= setup_end;
         fits_q   <= setup_fits;
      end else if (at_end) begin
         if (remain_q > ONE_C) begin
            remain_q <= remain_q - ONE_C;
         end else begin
            active_q <= 1'b0;
         end
      end
   end

   // R4: an armed loop always has at least one pass left
   assert_remain_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (remain_q != '0));

   // R4: the last pass disarms the loop
   assert_exhaust_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && remain_q == ONE_C && !flush && !setup_valid) |=> !active_q);

endmodule

// File: rtl/hwloop_buffer.sv
// Replay storage: one word and one valid bit per body offset.
module hwloop_buffer #(
   parameter int unsigned IW    = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [IW-1:0]   wr_data,
   input  logic            rd_en,
   input  logic [IDXW-1:0] rd_idx,
   output logic            hit,
   output logic [IW-1:0]   rd_data
);

   logic [DEPTH-1:0] valid_q;
   logic [IW-1:0]    word_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            valid_q[g] <= 1'b0;
         end else if (wr_en && (wr_idx == IDXW'(g))) begin
            valid_q[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDXW'(g))) begin
            word_q[g] <= wr_data;
         end
      end
   end

   assign hit     = rd_en && valid_q[rd_idx];
   assign rd_data = word_q[rd_idx];

   // R7: a captured word becomes servable on the next cycle
   assert_capture_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear) |=> valid_q[$past(wr_idx)]);

   // R9: a clear leaves nothing servable
   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (valid_q == '0));

endmodule

// File: rtl/hwloop_sequencer.sv
// Fetch sequencer with a single-level zero-overhead loop and replay buffer.
module hwloop_sequencer
   import hwloop_pkg::*;
#(
   parameter int unsigned AW         = DEF_ADDR_W,
   parameter int unsigned IW         = DEF_INSTR_W,
   parameter int unsigned CW         = DEF_COUNT_W,
   parameter int unsigned DEPTH      = DEF_DEPTH,
   parameter bit          USE_BUFFER = 1'b1,
   parameter int unsigned RESET_PC   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          setup_valid,
   input  logic [AW-1:0] setup_start,
   input  logic [AW-1:0] setup_end,
   input  logic [CW-1:0] setup_count,
   input  logic          flush,
   output logic          imem_req,
   output logic [AW-1:0] imem_addr,
   input  logic [IW-1:0] imem_rdata,
   output logic [AW-1:0] instr_pc,
   output logic [IW-1:0] instr_data,
   output logic          instr_from_buf,
   output logic          loop_active
);

   localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two, at least 2");
      assert (CW >= 2) else $fatal(1, "CW must be at least 2");
      assert (AW > IDXW) else $fatal(1, "AW must exceed the buffer index width");
   end

   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_next;
   logic          redirect;
   logic [AW-1:0] loop_start;
   logic          body_fits;
   logic          in_body;
   logic          buf_hit;
   logic [IW-1:0] buf_data;
   fetch_src_e    src;

   hwloop_ctrl #(
      .AW    (AW),
      .CW    (CW),
      .DEPTH (DEPTH)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .setup_valid (setup_valid),
      .setup_start (setup_start),
      .setup_end   (setup_end),
      .setup_count (setup_count),
      .flush       (flush),
      .fetch_pc    (pc_q),
      .active_o    (loop_active),
      .redirect_o  (redirect),
      .start_o     (loop_start),
      .fits_o      (body_fits),
      .in_body_o   (in_body)
   );

   if (USE_BUFFER) begin : g_buf
      logic [IDXW-1:0] idx;
      logic            lookup;
      assign idx    = IDXW'(pc_q - loop_start);
      assign lookup = body_fits && in_body;

      hwloop_buffer #(
         .IW    (IW),
         .DEPTH (DEPTH)
      ) u_buf (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (flush || setup_valid),
         .wr_en   (lookup && !buf_hit),
         .wr_idx  (idx),
         .wr_data (imem_rdata),
         .rd_en   (lookup),
         .rd_idx  (idx),
         .hit     (buf_hit),
         .rd_data (buf_data)
      );
   end else begin : g_nobuf
      assign buf_hit  = 1'b0;
      assign buf_data = '0;
   end

   assign src            = buf_hit ? SRC_BUF : SRC_MEM;
   assign imem_req       = (src == SRC_MEM);
   assign imem_addr      = pc_q;
   assign instr_pc       = pc_q;
   assign instr_from_buf = (src == SRC_BUF);
   assign instr_data     = (src == SRC_BUF) ? buf_data : imem_rdata;
   assign pc_next        = redirect ? loop_start : (pc_q + AW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= AW'(RESET_PC);
      end else begin
         pc_q <= pc_next;
      end
   end

   // R3: a redirect lands on the first body address in the next cycle
   assert_redirect_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (pc_q == $past(loop_start)));

   // R10: without a redirect the fetch address steps by one
   assert_linear_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> (pc_q == $past(pc_q) + AW'(1)));

   // R9: flush disarms the loop
   assert_flush_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !loop_active);

   // R8: an oversized body is never served from the buffer
   assert_oversize_memory_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && !body_fits) |-> imem_req);

endmodule

// File: tb/hwloop_sequencer_tb.sv
`timescale 1ns/100ps
module hwloop_sequencer_tb;

   localparam int AW = 16;
   localparam int IW = 32;
   localparam int CW = 16;
   localparam int DEPTH = 8;
   localparam int NV = 7;
   localparam int NCYC = 60;

   // start, end, count, requirement tag per vector
   localparam int V_START [NV] = '{3, 2, 3, 3, 4,  2, 5};
   localparam int V_END   [NV] = '{6, 2, 5, 5, 14, 9, 7};
   localparam int V_COUNT [NV] = '{4, 4, 0, 1, 3,  3, 6};
   localparam int V_REQ   [NV] = '{3, 6, 5, 4, 8,  7, 7};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          setup_valid = 1'b0;
   logic [AW-1:0] setup_start = '0;
   logic [AW-1:0] setup_end = '0;
   logic [CW-1:0] setup_count = '0;
   logic          flush = 1'b0;
   logic          imem_req;
   logic [AW-1:0] imem_addr;
   logic [IW-1:0] imem_rdata;
   logic [AW-1:0] instr_pc;
   logic [IW-1:0] instr_data;
   logic          instr_from_buf;
   logic          loop_active;

   int errors = 0;
   int checks = 0;
   int wd = 0;

   always #2.5 clk = ~clk;

   function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
      return {a ^ 16'h5A3C, ~a};
   endfunction

   // Poison data whenever memory is not requested
   assign imem_rdata = imem_req ? mem_word(imem_addr) : 32'hDEAD_BEEF;

   hwloop_sequencer #(
      .AW (AW), .IW (IW), .CW (CW), .DEPTH (DEPTH)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .setup_valid    (setup_valid),
      .setup_start    (setup_start),
      .setup_end      (setup_end),
      .setup_count    (setup_count),
      .flush          (flush),
      .imem_req       (imem_req),
      .imem_addr      (imem_addr),
      .imem_rdata     (imem_rdata),
      .instr_pc       (instr_pc),
      .instr_data     (instr_data),
      .instr_from_buf (instr_from_buf),
      .loop_active    (loop_active)
   );

   function automatic string req_name(input int r);
      case (r)
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic start_loop(input int s, input int e, input int c);
      rst_n = 1'b0;
      setup_valid = 1'b0;
      flush = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      setup_valid = 1'b1;
      setup_start = AW'(s);
      setup_end = AW'(e);
      setup_count = CW'(c);
   endtask

   task automatic run_vector(input int s, input int e, input int c, input int r);
      int pc_m = 0;
      bit act = 0;
      int rem = 0;
      int pass = 1;
      bit fits = (e - s) < DEPTH;
      int bad_pc = 0, bad_data = 0, bad_fb = 0, bad_req = 0;
      int first_act = 0, first_exp = 0;
      bit armed = 0;
      string tag = req_name(r);
      start_loop(s, e, c);
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         bit exp_fb;
         #1;
         exp_fb = act && fits && pass >= 2 && pc_m >= s && pc_m <= e;
         if (instr_pc !== AW'(pc_m)) begin
            if (bad_pc == 0) begin first_act = int'(instr_pc); first_exp = pc_m; end
            bad_pc++;
         end
         if (instr_data !== mem_word(AW'(pc_m))) bad_data++;
         if (instr_from_buf !== exp_fb) bad_fb++;
         if (imem_req !== !exp_fb) bad_req++;
         if (cyc == 1) armed = loop_active;
         if (act && pc_m == e) begin
            if (rem > 1) begin rem--; pass++; pc_m = s; end
            else begin act = 0; pc_m++; end
         end else begin
            pc_m++;
         end
         if (cyc == 0) begin act = 1; rem = (c == 0) ? 1 : c; end
         @(posedge clk);
         @(negedge clk);
         setup_valid = 1'b0;
      end
      // R3 / R4 / R5 / R6 / R8 / R10: fetch address sequence
      check(bad_pc == 0, tag, "first pc mismatch", first_act, first_exp);
      // R7: data correct even when memory returns poison
      check(bad_data == 0, tag, "data mismatches (R7)", bad_data, 0);
      check(bad_fb == 0, tag, "buffer-source mismatches (R7/R8)", bad_fb, 0);
      check(bad_req == 0, tag, "imem_req mismatches (R7)", bad_req, 0);
      // R2: armed from the fetch after setup
      check(armed == 1'b1, tag, "loop_active after setup (R2)", armed, 1);
      // R4: disarmed after the last pass
      check(loop_active == 1'b0, tag, "loop_active at end (R4)", loop_active, 0);
   endtask

   // Setup 3..5 x5; raise flush in cycle fcyc; expect pc_at then pc_at+1, pc_at+2
   task automatic flush_test(input int fcyc, input int pc_at, input bit fb_at);
      start_loop(3, 5, 5);
      for (int cyc = 0; cyc < fcyc; cyc++) begin
         @(posedge clk);
         @(negedge clk);
         setup_valid = 1'b0;
      end
      #1;
      check(instr_pc == AW'(pc_at), "R9", "pc at flush", instr_pc, pc_at);
      check(instr_from_buf == fb_at, "R9", "source at flush", instr_from_buf, fb_at);
      flush = 1'b1;
      @(posedge clk);
      @(negedge clk);
      flush = 1'b0;
      #1;
      check(instr_pc == AW'(pc_at + 1), "R9", "pc after flush", instr_pc, pc_at + 1);
      check(loop_active == 1'b0, "R9", "loop_active after flush", loop_active, 0);
      check(instr_from_buf == 1'b0 && imem_req == 1'b1, "R9", "memory source after flush",
            instr_from_buf, 0);
      check(instr_data == mem_word(AW'(pc_at + 1)), "R9", "data after flush",
            instr_data, mem_word(AW'(pc_at + 1)));
      @(posedge clk);
      @(negedge clk);
      #1;
      // R10: linear stepping once the loop is gone
      check(instr_pc == AW'(pc_at + 2), "R10", "pc two after flush", instr_pc, pc_at + 2);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1: actual=%0d expected<=%0d cycles", wd, 20000);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state, setup ignored while in reset
      rst_n = 1'b0;
      setup_valid = 1'b1;
      setup_start = 16'd0;
      setup_end = 16'd0;
      setup_count = 16'd3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check(instr_pc == '0, "R1", "pc in reset", instr_pc, 0);
      check(loop_active == 1'b0, "R1", "loop_active in reset", loop_active, 0);
      check(instr_from_buf == 1'b0, "R1", "buffer source in reset", instr_from_buf, 0);
      check(imem_req == 1'b1, "R1", "imem_req in reset", imem_req, 1);
      setup_valid = 1'b0;

      // Table of loop shapes
      for (int v = 0; v < NV; v++) begin
         run_vector(V_START[v], V_END[v], V_COUNT[v], V_REQ[v]);
      end

      // R9: flush mid second pass (pc 4 served from buffer)
      flush_test(7, 4, 1'b1);
      // R9: flush exactly on the end address with passes left: no redirect
      flush_test(5, 5, 1'b0);

      summary();
      $finish;
   end

endmodule